// File: doc/BRIEF.md
# Hardware Ticket Lock Unit

This block provides first-come, first-served mutual exclusion among a fixed set of requesters. It can hold several independent locks. Each lock has two small counters. The first hands out tickets. The second says which ticket may hold the lock now. A requester asks for a lock by index. It receives the next ticket of that lock, which is then bumped by one in the same atomic step. The requester is granted the lock when the serving counter reaches its ticket. A release bumps the serving counter, and the lock passes to the next ticket in line.

Every requester has its own acquire and release request lines, acknowledge pulses and a grant line. A requester holds at most one ticket at a time. When several requesters ask in the same cycle, a fixed-priority picker takes one of them per cycle, so every ticket handed out is unique and consecutive. Counters are TW bits wide and wrap. Tickets are compared only for equality, so the wrap does no harm while fewer than 2^TW requesters wait on one lock.

Top module: `ticket_lock_unit`

## Requirements
- R1: After reset all counters are zero, every ticket register reads zero, and grant, acqAck, relAck and relErr are low, so the first ticket issued on any lock is 0.
- R2: A requester holding no ticket that raises acqReq (held high until acked) is accepted on a clock edge. It receives the current next-ticket value of the lock selected by its acqLock field (LOCK_W bits at offset i*LOCK_W) on acqTicket (TW bits at offset i*TW). acqAck[i] pulses high for the one cycle after that edge, and the lock's next-ticket value grows by one.
- R3: Among eligible acquire requests, one is accepted per cycle and the lowest requester index goes first, so simultaneous requesters on one lock get consecutive tickets in index order.
- R4: grant[i] rises one cycle after the stored ticket of requester i equals the serving value of its lock, and it stays high until that requester releases.
- R5: relReq[i] sampled while grant[i] is high is a valid release. It bumps the lock's serving value by one, pulses relAck[i] for one cycle, and drops grant[i] in that same cycle.
- R6: relReq[i] sampled while grant[i] is low is ignored: no counter changes, the grant vector stays the same, and relErr[i] pulses for one cycle with relAck[i] low.
- R7: At most one requester is granted a given lock at any time, and the lock is handed over in ticket order.
- R8: Both counters wrap modulo 2^TW, and granting keeps working across the wrap.
- R9: Locks are independent: traffic on one lock never changes the tickets or grants of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| acqReq | input | REQS | Acquire request level per requester |
| acqLock | input | REQS*LOCK_W | Lock index per requester |
| acqAck | output | REQS | One-cycle acquire acknowledge |
| acqTicket | output | REQS*TW | Ticket held by each requester |
| relReq | input | REQS | Release request per requester, sampled each cycle |
| relAck | output | REQS | One-cycle release acknowledge |
| relErr | output | REQS | One-cycle flag for an ignored release |
| grant | output | REQS | Requester currently holds its lock |

## Verification
The bench sweeps every non-empty set of simultaneous acquirers against every assignment of requesters to the two locks. This tells priority order and per-lock ticket numbering apart from a shared counter. After each burst, a release from a non-holder checks that the error path leaves all state alone. The holders then release one at a time, which checks each handover and the order in which the lock passes on. The counters are carried across all combinations without a reset, so they wrap many times, and a comparison that relied on magnitude rather than equality would fail.

// File: rtl/tl_pkg.sv
package tl_pkg;
  parameter int REQS  = 4;
  parameter int LOCKS = 2;
  parameter int TW    = 3;

  localparam int REQ_W  = (REQS  > 1) ? $clog2(REQS)  : 1;
  localparam int LOCK_W = (LOCKS > 1) ? $clog2(LOCKS) : 1;

  typedef struct packed {
    logic              grab;
    logic [REQ_W-1:0]  grabWho;
    logic [REQS-1:0]   relOk;
  } tl_strobe_t;
endpackage

// File: rtl/tl_datapath.sv
module tl_datapath
  import tl_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  tl_strobe_t             st,
  input  logic [REQS*LOCK_W-1:0] acqLock,
  output logic [REQS*TW-1:0]     ticketFlat,
  output logic [REQS*LOCK_W-1:0] lockFlat,
  output logic [REQS-1:0]        matchNow
);
  logic [TW-1:0]     nextT  [LOCKS];
  logic [TW-1:0]     serveT [LOCKS];
  logic [TW-1:0]     tkt    [REQS];
  logic [LOCK_W-1:0] lockOf [REQS];
  logic [LOCK_W-1:0] grabLock;
  logic [LOCKS-1:0]  bump;

  assign grabLock = acqLock[st.grabWho*LOCK_W +: LOCK_W];

  genvar l, r;
  generate
    for (l = 0; l < LOCKS; l++) begin : g_lock
      logic [REQS-1:0] relHere;
      for (r = 0; r < REQS; r++) begin : g_sel
        assign relHere[r] = st.relOk[r] && (lockOf[r] == LOCK_W'(l));
      end
      assign bump[l] = |relHere;

      always_ff @(posedge clk) begin
        if (!rstN) begin
          nextT[l]  <= '0;
          serveT[l] <= '0;
        end else begin
          if (st.grab && grabLock == LOCK_W'(l)) nextT[l] <= nextT[l] + 1'b1;
          if (bump[l]) serveT[l] <= serveT[l] + 1'b1;
        end
      end

      // R7 / R8: outstanding tickets never exceed the requester count
      a_r7_window: assert property (@(posedge clk) disable iff (!rstN)
        int'(TW'(nextT[l] - serveT[l])) <= REQS);
      // R7: only one valid release per lock per cycle
      a_r7_single_release: assert property (@(posedge clk) disable iff (!rstN)
        $countones(relHere) <= 1);
    end

    for (r = 0; r < REQS; r++) begin : g_req
      always_ff @(posedge clk) begin
        if (!rstN) begin
          tkt[r]    <= '0;
          lockOf[r] <= '0;
        end else if (st.grab && st.grabWho == REQ_W'(r)) begin
          tkt[r]    <= nextT[grabLock];
          lockOf[r] <= grabLock;
        end
      end
      assign matchNow[r]                   = (tkt[r] == serveT[lockOf[r]]);
      assign ticketFlat[r*TW +: TW]        = tkt[r];
      assign lockFlat[r*LOCK_W +: LOCK_W]  = lockOf[r];
    end
  endgenerate

  // R2: accepted requester stores the pre-increment next-ticket value
  a_r2_ticket_taken: assert property (@(posedge clk) disable iff (!rstN)
    st.grab |=> tkt[$past(st.grabWho)] == $past(nextT[grabLock]));
  // R2 / R8: next-ticket grows by one, modulo 2^TW
  a_r2_next_bump: assert property (@(posedge clk) disable iff (!rstN)
    st.grab |=> nextT[$past(grabLock)] == TW'($past(nextT[grabLock]) + 1'b1));
endmodule

// File: rtl/tl_control.sv
module tl_control
  import tl_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic [REQS-1:0] acqReq,
  input  logic [REQS-1:0] relReq,
  input  logic [REQS-1:0] matchNow,
  output tl_strobe_t      st,
  output logic [REQS-1:0] acqAck,
  output logic [REQS-1:0] relAck,
  output logic [REQS-1:0] relErr,
  output logic [REQS-1:0] grant
);
  logic [REQS-1:0]  hasTkt;
  logic [REQS-1:0]  elig;
  logic [REQS-1:0]  grabOneHot;
  logic [REQS-1:0]  relOk;
  logic [REQS-1:0]  relBad;
  logic             grab;
  logic [REQ_W-1:0] who;

  assign elig = acqReq & ~hasTkt;

  always_comb begin
    grab = 1'b0;
    who  = '0;
    for (int i = REQS - 1; i >= 0; i--) begin
      if (elig[i]) begin
        grab = 1'b1;
        who  = REQ_W'(i);
      end
    end
  end

  assign grabOneHot = grab ? (REQS'(1) << who) : '0;
  assign relOk      = relReq & grant;
  assign relBad     = relReq & ~grant;

  assign st.grab    = grab;
  assign st.grabWho = who;
  assign st.relOk   = relOk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hasTkt <= '0;
      grant  <= '0;
      acqAck <= '0;
      relAck <= '0;
      relErr <= '0;
    end else begin
      hasTkt <= (hasTkt | grabOneHot) & ~relOk;
      grant  <= hasTkt & ~relOk & matchNow;
      acqAck <= grabOneHot;
      relAck <= relOk;
      relErr <= relBad;
    end
  end

  // R3: at most one acquire accepted per cycle
  a_r3_one_ack: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(acqAck));

  genvar r;
  generate
    for (r = 0; r < REQS; r++) begin : g_chk
      // R2: an ack always answers a pending request
      a_r2_ack_has_req: assert property (@(posedge clk) disable iff (!rstN)
        acqAck[r] |-> $past(acqReq[r]));
      // R4: grant stays until the holder releases
      a_r4_grant_held: assert property (@(posedge clk) disable iff (!rstN)
        (grant[r] && !relReq[r]) |=> grant[r]);
      // R4: grant only for a requester holding a ticket
      a_r4_grant_ticket: assert property (@(posedge clk) disable iff (!rstN)
        grant[r] |-> hasTkt[r]);
      // R5: a release ack comes with the grant dropped
      a_r5_ack_drops: assert property (@(posedge clk) disable iff (!rstN)
        relAck[r] |-> !grant[r]);
      // R6: error only for a release from a non-holder
      a_r6_err_nonholder: assert property (@(posedge clk) disable iff (!rstN)
        relErr[r] |-> !$past(grant[r]));
    end
  endgenerate
endmodule

// File: rtl/ticket_lock_unit.sv
module ticket_lock_unit
  import tl_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [REQS-1:0]        acqReq,
  input  logic [REQS*LOCK_W-1:0] acqLock,
  output logic [REQS-1:0]        acqAck,
  output logic [REQS*TW-1:0]     acqTicket,
  input  logic [REQS-1:0]        relReq,
  output logic [REQS-1:0]        relAck,
  output logic [REQS-1:0]        relErr,
  output logic [REQS-1:0]        grant
);
  tl_strobe_t             st;
  logic [REQS-1:0]        matchNow;
  logic [REQS*LOCK_W-1:0] lockFlat;

  tl_control u_ctrl (
    .clk(clk), .rstN(rstN), .acqReq(acqReq), .relReq(relReq),
    .matchNow(matchNow), .st(st), .acqAck(acqAck), .relAck(relAck),
    .relErr(relErr), .grant(grant)
  );

  tl_datapath u_dp (
    .clk(clk), .rstN(rstN), .st(st), .acqLock(acqLock),
    .ticketFlat(acqTicket), .lockFlat(lockFlat), .matchNow(matchNow)
  );

  genvar l, r;
  generate
    for (l = 0; l < LOCKS; l++) begin : g_mutex
      logic [REQS-1:0] holds;
      for (r = 0; r < REQS; r++) begin : g_h
        assign holds[r] = grant[r] && (lockFlat[r*LOCK_W +: LOCK_W] == LOCK_W'(l));
      end
      // R7: a lock has at most one holder
      a_r7_one_holder: assert property (@(posedge clk) disable iff (!rstN)
        $countones(holds) <= 1);
    end
  endgenerate
endmodule

// File: tb/ticket_lock_unit_tb.sv
module ticket_lock_unit_tb;
  import tl_pkg::*;

  logic                   clk = 1'b0;
  logic                   rstN;
  logic [REQS-1:0]        acqReq;
  logic [REQS*LOCK_W-1:0] acqLock;
  logic [REQS-1:0]        acqAck;
  logic [REQS*TW-1:0]     acqTicket;
  logic [REQS-1:0]        relReq;
  logic [REQS-1:0]        relAck;
  logic [REQS-1:0]        relErr;
  logic [REQS-1:0]        grant;

  int  vectors = 0;
  int  fails   = 0;
  bit  done    = 0;

  int  mNext  [LOCKS];
  int  mServe [LOCKS];
  int  mTkt   [REQS];
  int  mLock  [REQS];
  bit  mHas   [REQS];

  localparam int MODV = 1 << TW;

  always #2 clk = ~clk;

  ticket_lock_unit u_dut (
    .clk(clk), .rstN(rstN), .acqReq(acqReq), .acqLock(acqLock),
    .acqAck(acqAck), .acqTicket(acqTicket), .relReq(relReq),
    .relAck(relAck), .relErr(relErr), .grant(grant)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [REQS-1:0] expGrant();
    logic [REQS-1:0] g = '0;
    for (int i = 0; i < REQS; i++)
      g[i] = mHas[i] && (mTkt[i] == mServe[mLock[i]]);
    return g;
  endfunction

  function automatic int lowestNonGranted(input logic [REQS-1:0] g);
    for (int i = 0; i < REQS; i++) if (!g[i]) return i;
    return -1;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; acqReq = '0; acqLock = '0; relReq = '0;
    for (int l = 0; l < LOCKS; l++) begin mNext[l] = 0; mServe[l] = 0; end
    for (int i = 0; i < REQS; i++) begin mTkt[i] = 0; mLock[i] = 0; mHas[i] = 0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 grant",  32'(grant),     0);
    chk("R1 acqAck", 32'(acqAck),    0);
    chk("R1 relAck", 32'(relAck),    0);
    chk("R1 relErr", 32'(relErr),    0);
    chk("R1 ticket", 32'(acqTicket), 0);
    rstN = 1'b1;
    @(negedge clk);

    for (int mask = 1; mask < (1 << REQS); mask++) begin
      for (int lp = 0; lp < (1 << REQS); lp++) begin
        // drive a burst of simultaneous acquires (R3), lock per requester from lp (R9)
        for (int i = 0; i < REQS; i++) begin
          acqLock[i*LOCK_W +: LOCK_W] = LOCK_W'((lp >> i) & 1);
          acqReq[i] = mask[i];
        end
        for (int i = 0; i < REQS; i++) begin
          if (mask[i]) begin
            @(negedge clk);
            chk("R3 ack order", 32'(acqAck), 32'(1 << i));
            // R2 / R8 / R9: ticket from the selected lock's counter, modulo 2^TW
            chk("R2 ticket", 32'(acqTicket[i*TW +: TW]), 32'(mNext[(lp >> i) & 1]));
            mLock[i] = (lp >> i) & 1;
            mTkt[i]  = mNext[mLock[i]];
            mHas[i]  = 1;
            mNext[mLock[i]] = (mNext[mLock[i]] + 1) % MODV;
            acqReq[i] = 1'b0;
          end
        end
        @(negedge clk);
        chk("R2 ack single cycle", 32'(acqAck), 0);
        chk("R4 grant after burst", 32'(grant), 32'(expGrant()));

        // R6: release from a non-holder is ignored and flagged
        begin
          int j;
          j = lowestNonGranted(expGrant());
          if (j >= 0) begin
            relReq[j] = 1'b1;
            @(negedge clk);
            relReq[j] = 1'b0;
            chk("R6 relErr", 32'(relErr), 32'(1 << j));
            chk("R6 no relAck", 32'(relAck), 0);
            chk("R6 grant same", 32'(grant), 32'(expGrant()));
            @(negedge clk);
            chk("R6 state unchanged", 32'(grant), 32'(expGrant()));
          end
        end

        // R5 / R7: release holders one by one, check handover in ticket order
        for (int step = 0; step < REQS; step++) begin
          logic [REQS-1:0] g;
          int h;
          g = expGrant();
          h = -1;
          for (int i = REQS - 1; i >= 0; i--) if (g[i]) h = i;
          if (h >= 0) begin
            relReq[h] = 1'b1;
            @(negedge clk);
            relReq[h] = 1'b0;
            chk("R5 relAck", 32'(relAck), 32'(1 << h));
            chk("R5 no relErr", 32'(relErr), 0);
            chk("R5 grant drops", 32'(grant[h]), 0);
            mServe[mLock[h]] = (mServe[mLock[h]] + 1) % MODV;
            mHas[h] = 0;
            @(negedge clk);
            chk("R7 handover", 32'(grant), 32'(expGrant()));
          end
        end
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule